// File: doc/BRIEF.md
# GPIO Port with Interrupt Capture

This block is a 32-pin general-purpose I/O port reached over a plain 32-bit register bus that has a write strobe, a byte address and a read path that answers at once. Software can load the output and direction registers whole, or change single bits through separate write-one-to-set and write-one-to-clear addresses. Because each of these addresses changes only the bits written as 1, two agents never need a read-modify-write sequence.

Every pad input passes through a two-stage synchroniser. The synchronised value is both the readable input register and the source for interrupt detection. Three per-pin bit-planes choose the trigger for each pin:
- a mode plane selects level or edge detection;
- a sense plane selects active-high/rising or active-low/falling;
- a dual plane makes an edge-mode pin fire on both edges.

Detected events gather in a sticky capture register that software clears by writing 1s. The events are masked by a per-pin enable and then merged into one interrupt line.

Top module: `gpio_port_irq`

## Requirements
- R1: After reset, every register reads 0, except the sense register (offset 0x18), which reads 0xFFFFFFFF. The interrupt output is low.
- R2: A write to offset 0x00 loads the output register. Writing to 0x40 sets, and writing to 0x44 clears, only the bits written as 1. The output register drives padOut, and reading 0x00 returns it.
- R3: The direction register works the same way, at offset 0x08 for a full load, 0x48 to set and 0x4C to clear. A direction bit of 1 enables the pin's output driver (padOe).
- R4: Reading offset 0x04 returns padIn after two clock edges of synchronisation. A change made after an edge is not visible after one more edge, and is visible after the second.
- R5: A pin whose mode bit (offset 0x2C) is 0 is edge-triggered. Its sense bit (offset 0x18) selects the rising edge when 0 and the falling edge when 1. The opposite edge captures nothing.
- R6: An edge-mode pin whose dual bit (offset 0x1C) is 1 captures both rising and falling edges, whatever its sense bit holds.
- R7: A pin whose mode bit is 1 is level-triggered: high is active when its sense bit is 0, and low is active when it is 1. If a clear lands in the same cycle as a new event, the event wins, so the capture bit stays set while the active level persists.
- R8: The capture register at offset 0x20 keeps its bits set until software writes a 1 to that bit at 0x20. Bits written as 0 are left unchanged.
- R9: The enable mask changes only through offset 0x30 (bits written as 1 are set) and offset 0x34 (bits written as 1 are cleared). Reading either offset returns the mask.
- R10: irqOut is high exactly when at least one pin has both its capture bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Write strobe for the register at addr |
| addr | input | 8 | Byte offset of the register accessed |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for addr, combinational |
| padIn | input | 32 | Pin input levels, asynchronous |
| padOut | output | 32 | Pin output levels |
| padOe | output | 32 | Pin output enables, 1 means driven |
| irqOut | output | 1 | Combined interrupt request |

## Verification
Interrupt detection is driven with one pin per trigger type: rising-only, falling-only, dual-edge, level-high and level-low. Each pin is toggled in both directions, so the captured bit shows which edge or level the hardware actually sensed.

A pattern with many bits rising and then falling, applied under the reset sense setting, shows that the defaults select falling edges on every pin.

Holding a level active while clearing shows that an event has priority over a clear in the same cycle.

Enabling and disabling a pin whose capture bit stays set separates the masking behaviour from the capture behaviour.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFS_OUT    = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_IN     = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_DIR    = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_SENSE  = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_DUAL   = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_CAP    = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 8'h2C;
  localparam logic [ADDR_W-1:0] OFS_ENSET  = 8'h30;
  localparam logic [ADDR_W-1:0] OFS_ENCLR  = 8'h34;
  localparam logic [ADDR_W-1:0] OFS_OUTSET = 8'h40;
  localparam logic [ADDR_W-1:0] OFS_OUTCLR = 8'h44;
  localparam logic [ADDR_W-1:0] OFS_DIRSET = 8'h48;
  localparam logic [ADDR_W-1:0] OFS_DIRCLR = 8'h4C;

  typedef enum logic [3:0] {
    RD_NONE, RD_OUT, RD_IN, RD_DIR, RD_SENSE, RD_DUAL, RD_CAP, RD_MODE, RD_EN
  } rdSel_e;

  typedef struct packed {
    logic loadOut;
    logic setOut;
    logic clrOut;
    logic loadDir;
    logic setDir;
    logic clrDir;
    logic loadSense;
    logic loadDual;
    logic loadMode;
    logic clrCap;
    logic setEn;
    logic clrEn;
  } regStrobe_t;
endpackage

// File: rtl/gpio_ctrl.sv
module gpio_ctrl
  import gpio_pkg::*;
(
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  output regStrobe_t        strb,
  output rdSel_e            rdSel
);
  always_comb begin
    strb  = '0;
    rdSel = RD_NONE;
    case (addr)
      OFS_OUT:    begin rdSel = RD_OUT;   strb.loadOut   = wrEn; end
      OFS_IN:     begin rdSel = RD_IN; end
      OFS_DIR:    begin rdSel = RD_DIR;   strb.loadDir   = wrEn; end
      OFS_SENSE:  begin rdSel = RD_SENSE; strb.loadSense = wrEn; end
      OFS_DUAL:   begin rdSel = RD_DUAL;  strb.loadDual  = wrEn; end
      OFS_CAP:    begin rdSel = RD_CAP;   strb.clrCap    = wrEn; end
      OFS_MODE:   begin rdSel = RD_MODE;  strb.loadMode  = wrEn; end
      OFS_ENSET:  begin rdSel = RD_EN;    strb.setEn     = wrEn; end
      OFS_ENCLR:  begin rdSel = RD_EN;    strb.clrEn     = wrEn; end
      OFS_OUTSET: strb.setOut = wrEn;
      OFS_OUTCLR: strb.clrOut = wrEn;
      OFS_DIRSET: strb.setDir = wrEn;
      OFS_DIRCLR: strb.clrDir = wrEn;
      default:    rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_pin_detect.sv
module gpio_pin_detect (
  input  logic curLvl,
  input  logic prevLvl,
  input  logic levelMode,
  input  logic negSense,
  input  logic dualEdge,
  output logic evt
);
  logic rise;
  logic fall;
  logic edgeHit;
  logic levelHit;

  assign rise     = curLvl & ~prevLvl;
  assign fall     = ~curLvl & prevLvl;
  assign edgeHit  = dualEdge ? (rise | fall) : (negSense ? fall : rise);
  assign levelHit = negSense ? ~curLvl : curLvl;
  assign evt      = levelMode ? levelHit : edgeHit;
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  rdSel_e              rdSel,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] outReg,
  output logic [NUM_PINS-1:0] dirReg,
  output logic [NUM_PINS-1:0] capReg,
  output logic [NUM_PINS-1:0] enReg,
  output logic [NUM_PINS-1:0] inSync
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] syncChain [SYNC_STAGES];
  logic [NUM_PINS-1:0] prevSync;
  logic [NUM_PINS-1:0] senseReg;
  logic [NUM_PINS-1:0] dualReg;
  logic [NUM_PINS-1:0] modeReg;
  logic [NUM_PINS-1:0] evtVec;
  logic [NUM_PINS-1:0] capClrMask;

  assign inSync = syncChain[LAST_STAGE];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < SYNC_STAGES; i++) syncChain[i] <= '0;
      prevSync <= '0;
    end else begin
      syncChain[0] <= padIn;
      for (int i = 1; i < SYNC_STAGES; i++) syncChain[i] <= syncChain[i-1];
      prevSync <= syncChain[LAST_STAGE];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outReg   <= '0;
      dirReg   <= '0;
      senseReg <= '1;
      dualReg  <= '0;
      modeReg  <= '0;
      enReg    <= '0;
    end else begin
      if (strb.loadOut)      outReg <= wrData;
      else if (strb.setOut)  outReg <= outReg | wrData;
      else if (strb.clrOut)  outReg <= outReg & ~wrData;

      if (strb.loadDir)      dirReg <= wrData;
      else if (strb.setDir)  dirReg <= dirReg | wrData;
      else if (strb.clrDir)  dirReg <= dirReg & ~wrData;

      if (strb.loadSense) senseReg <= wrData;
      if (strb.loadDual)  dualReg  <= wrData;
      if (strb.loadMode)  modeReg  <= wrData;

      if (strb.setEn)       enReg <= enReg | wrData;
      else if (strb.clrEn)  enReg <= enReg & ~wrData;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gen_pin
    gpio_pin_detect u_det (
      .curLvl   (inSync[g]),
      .prevLvl  (prevSync[g]),
      .levelMode(modeReg[g]),
      .negSense (senseReg[g]),
      .dualEdge (dualReg[g]),
      .evt      (evtVec[g])
    );
  end

  assign capClrMask = strb.clrCap ? wrData : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) capReg <= '0;
    else       capReg <= (capReg & ~capClrMask) | evtVec;
  end

  always_comb begin
    case (rdSel)
      RD_OUT:   rdData = outReg;
      RD_IN:    rdData = inSync;
      RD_DIR:   rdData = dirReg;
      RD_SENSE: rdData = senseReg;
      RD_DUAL:  rdData = dualReg;
      RD_CAP:   rdData = capReg;
      RD_MODE:  rdData = modeReg;
      RD_EN:    rdData = enReg;
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wrData,
  output logic [NUM_PINS-1:0] rdData,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic                irqOut
);
  regStrobe_t          strb;
  rdSel_e              rdSel;
  logic [NUM_PINS-1:0] capMask;
  logic [NUM_PINS-1:0] enMask;
  logic [NUM_PINS-1:0] inData;

  gpio_ctrl u_ctrl (
    .wrEn (wrEn),
    .addr (addr),
    .strb (strb),
    .rdSel(rdSel)
  );

  gpio_datapath #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strb  (strb),
    .rdSel (rdSel),
    .wrData(wrData),
    .padIn (padIn),
    .rdData(rdData),
    .outReg(padOut),
    .dirReg(padOe),
    .capReg(capMask),
    .enReg (enMask),
    .inSync(inData)
  );

  assign irqOut = |(capMask & enMask);
endmodule

// File: rtl/gpio_port_irq_chk.sv
module gpio_port_irq_chk
  import gpio_pkg::*;
#(
  parameter int NUM_PINS    = 32,
  parameter int SYNC_STAGES = 2
) (
  input logic                clk,
  input logic                rstN,
  input logic                wrEn,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wrData,
  input logic [NUM_PINS-1:0] padIn,
  input logic [NUM_PINS-1:0] padOut,
  input logic [NUM_PINS-1:0] padOe,
  input logic                irqOut,
  input logic [NUM_PINS-1:0] capMask,
  input logic [NUM_PINS-1:0] enMask,
  input logic [NUM_PINS-1:0] inData
);
  logic [1:0] warmCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                warmCnt <= '0;
    else if (warmCnt != 2'd3) warmCnt <= warmCnt + 2'd1;
  end

  // R2: bits written to the output-set address are high afterwards
  assert_out_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_OUTSET) |=> ((padOut & $past(wrData)) == $past(wrData)));

  // R3: bits written to the direction-clear address are low afterwards
  assert_dir_clr_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == OFS_DIRCLR) |=> ((padOe & $past(wrData)) == '0));

  // R4: the input register trails the pad by two edges
  if (SYNC_STAGES == 2) begin : gen_sync_chk
    assert_sync_delay_R4: assert property (@(posedge clk) disable iff (!rstN)
      (warmCnt >= 2'd2) |-> (inData == $past(padIn, 2)));
  end

  // R8: capture bits drop only through a write to the capture address
  assert_cap_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && addr == OFS_CAP) |=> ((capMask & $past(capMask)) == $past(capMask)));

  // R9: the enable mask holds unless the set or clear address is written
  assert_en_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(wrEn && (addr == OFS_ENSET || addr == OFS_ENCLR)) |=> $stable(enMask));

  // R10: no request without an enabled capture
  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rstN)
    ((capMask & enMask) == '0) |-> !irqOut);
endmodule

bind gpio_port_irq gpio_port_irq_chk #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk    (clk),
  .rstN   (rstN),
  .wrEn   (wrEn),
  .addr   (addr),
  .wrData (wrData),
  .padIn  (padIn),
  .padOut (padOut),
  .padOe  (padOe),
  .irqOut (irqOut),
  .capMask(capMask),
  .enMask (enMask),
  .inData (inData)
);

// File: tb/gpio_port_irq_tb.sv
module gpio_port_irq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] padIn = '0;
  logic [31:0] padOut;
  logic [31:0] padOe;
  logic        irqOut;

  always #4 clk = ~clk;

  gpio_port_irq u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .padIn(padIn), .padOut(padOut), .padOe(padOe), .irqOut(irqOut)
  );

  typedef struct {
    int          kind;   // 0 rdData, 1 irqOut, 2 padOut, 3 padOe
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t scoreQ[$];
  logic  chkValid = 1'b0;
  int    nCompared = 0;
  int    nMismatch = 0;
  bit    finished = 1'b0;

  always @(negedge clk) begin
    if (chkValid && scoreQ.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = scoreQ.pop_front();
      case (it.kind)
        0: act = rdData;
        1: act = {31'd0, irqOut};
        2: act = padOut;
        default: act = padOe;
      endcase
      nCompared++;
      if (act !== it.exp) begin
        nMismatch++;
        $display("FAIL %s actual=%08h expected=%08h", it.tag, act, it.exp);
      end
    end
  end

  task automatic expectItem(input int kind, input logic [7:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    addr = a;
    it.kind = kind; it.exp = e; it.tag = tag;
    scoreQ.push_back(it);
    chkValid = 1'b1;
    @(posedge clk); #1;
    chkValid = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    expectItem(0, a, e, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = a; wrData = d; wrEn = 1'b1;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic pad(input logic [31:0] v);
    @(posedge clk); #1;
    padIn = v;
    repeat (4) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    rd(8'h00, 32'h0, "R1 out");
    rd(8'h08, 32'h0, "R1 dir");
    rd(8'h18, 32'hFFFF_FFFF, "R1 sense");
    rd(8'h1C, 32'h0, "R1 dual");
    rd(8'h2C, 32'h0, "R1 mode");
    rd(8'h20, 32'h0, "R1 cap");
    rd(8'h30, 32'h0, "R1 en");
    expectItem(1, 8'h00, 32'h0, "R1 irq");

    // R2 output register
    wr(8'h00, 32'hA5A5_0000);
    rd(8'h00, 32'hA5A5_0000, "R2 load");
    wr(8'h40, 32'h0000_00FF);
    expectItem(2, 8'h00, 32'hA5A5_00FF, "R2 set padOut");
    wr(8'h44, 32'hA000_000F);
    rd(8'h00, 32'h05A5_00F0, "R2 clear");

    // R3 direction register
    wr(8'h08, 32'h0F0F_0000);
    wr(8'h48, 32'h0000_0003);
    expectItem(3, 8'h00, 32'h0F0F_0003, "R3 set padOe");
    wr(8'h4C, 32'h0100_0001);
    rd(8'h08, 32'h0E0F_0002, "R3 clear");

    // R4 synchroniser latency
    @(posedge clk); #1 padIn = 32'h1234_5678;
    rd(8'h04, 32'h0, "R4 one edge");
    rd(8'h04, 32'h1234_5678, "R4 two edges");

    // R5 reset sense is falling edge on every pin
    pad(32'h0);
    rd(8'h20, 32'h1234_5678, "R5 default falling");
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, 32'h0, "R8 clear all");

    // R5 rising edge on pin 0
    wr(8'h18, 32'h0000_0012);
    pad(32'h0000_0001);
    rd(8'h20, 32'h0000_0001, "R5 rising captured");
    wr(8'h20, 32'h0000_0001);
    pad(32'h0);
    rd(8'h20, 32'h0, "R5 falling ignored");

    // R5 falling edge on pin 1
    pad(32'h0000_0002);
    rd(8'h20, 32'h0, "R5 rising ignored neg");
    pad(32'h0);
    rd(8'h20, 32'h0000_0002, "R5 falling captured");
    wr(8'h20, 32'h0000_0001);
    rd(8'h20, 32'h0000_0002, "R8 zero bit kept");
    wr(8'h20, 32'h0000_0002);

    // R6 dual edge on pin 2
    wr(8'h1C, 32'h0000_0004);
    pad(32'h0000_0004);
    rd(8'h20, 32'h0000_0004, "R6 rise");
    wr(8'h20, 32'h0000_0004);
    rd(8'h20, 32'h0, "R6 cleared");
    pad(32'h0);
    rd(8'h20, 32'h0000_0004, "R6 fall");
    wr(8'h20, 32'h0000_0004);

    // R7 level high on pin 3
    wr(8'h2C, 32'h0000_0008);
    pad(32'h0000_0008);
    rd(8'h20, 32'h0000_0008, "R7 high level");
    wr(8'h20, 32'h0000_0008);
    rd(8'h20, 32'h0000_0008, "R7 event beats clear");
    pad(32'h0);
    wr(8'h20, 32'h0000_0008);
    rd(8'h20, 32'h0, "R7 released");

    // R7 level low on pin 4
    wr(8'h2C, 32'h0000_0018);
    rd(8'h20, 32'h0000_0010, "R7 low level");
    pad(32'h0000_0010);
    wr(8'h20, 32'h0000_0010);
    rd(8'h20, 32'h0, "R7 low released");

    // R9 enable mask
    wr(8'h30, 32'h0000_0005);
    rd(8'h30, 32'h0000_0005, "R9 set read");
    wr(8'h34, 32'h0000_0001);
    rd(8'h34, 32'h0000_0004, "R9 clear read");
    expectItem(1, 8'h00, 32'h0, "R10 no capture");

    // R10 combined request
    pad(32'h0000_0014);
    expectItem(1, 8'h00, 32'h1, "R10 irq high");
    wr(8'h34, 32'h0000_0004);
    expectItem(1, 8'h00, 32'h0, "R10 masked");
    rd(8'h20, 32'h0000_0004, "R10 capture kept");
    wr(8'h30, 32'h0000_0004);
    expectItem(1, 8'h00, 32'h1, "R10 unmasked");
    wr(8'h20, 32'h0000_0004);
    expectItem(1, 8'h00, 32'h0, "R10 cleared");

    repeat (2) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nMismatch++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end
endmodule